// File: doc/BRIEF.md
# Timing Event Link Transmitter

This block puts timing event codes from two sources onto one serial event link, one code per frame. Hardware events come from a bank of trigger inputs. Each input is edge-detected and stands for a fixed code in the range 0 to 63. Software events are written by a host into a small queue and must carry codes from 64 to 255. When more than one event is waiting at a frame boundary, a fixed priority picks the next code to send.

Frames are timed by a one-cycle bit tick supplied from outside, so the link bit rate follows whatever clock the tick is derived from. A cycle-start pulse marks the beginning of each machine cycle. It opens a time-critical window that lasts a programmable number of bit ticks. Inside that window only hardware events go out, and queued software events wait until the window closes.

Top module: `evt_link_tx`

## Requirements
- R1: After reset, link_out, sw_err and sw_full are all 0.
- R2: A frame is one bit time each of: a start bit of 1, the 8 code bits with the most significant bit first, a parity bit that makes the total number of ones in code plus parity even, and a guard bit of 0. link_out changes only on a clock edge where bit_tick is high.
- R3: A rising edge on hw_trig[i] queues code i. It stays pending until it is sent. A trigger held high produces exactly one event.
- R4: A frame can start only on a bit tick, and the code is chosen at that moment. Any pending hardware code goes before any software code, and among hardware codes the lowest number goes first.
- R5: Software codes are sent in the order they were written. The queue holds SW_DEPTH entries, and sw_full is 1 while it is full. A write made while the queue is full is dropped.
- R6: A software write with a code below 64 is not queued and sets sw_err. sw_err stays at 1 until reset.
- R7: A cycle_start pulse loads a window of win_len bit ticks. While the window is open no software frame starts, but hardware frames still do.
- R8: A cycle_start pulse with win_len equal to 0 opens no window, and queued software codes are sent at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle pulse for each link bit time |
| hw_trig | input | HW_GROUPS*16 | Hardware trigger inputs; bit i raises code i |
| sw_wr | input | 1 | Software write strobe |
| sw_code | input | 8 | Software event code |
| cycle_start | input | 1 | Start of machine cycle; opens the window |
| win_len | input | WIN_W | Length of the window in bit ticks |
| link_out | output | 1 | Serial event link |
| sw_err | output | 1 | Sticky flag for a rejected software code |
| sw_full | output | 1 | Software queue is full |

## Verification
Every decision inside this block shows up on link_out within one frame, which is eleven bit ticks. A lost pending latch, a wrong priority order or a queue pointer slip appears as a missing, extra or reordered code in the received frame stream. Window counter faults show up as a change in the time from cycle_start to the first software frame, so that delay is measured against the programmed length. Rejection and fullness faults show up on sw_err and sw_full one cycle after the write, and in frames that should be absent.

// File: rtl/evt_link_pkg.sv
package evt_link_pkg;
   localparam int CODE_W    = 8;
   localparam int HW_LIMIT  = 64;
   localparam int GROUP_SZ  = 16;
   localparam int FRAME_LEN = 11;
   localparam int CNT_W     = $clog2(FRAME_LEN);

   function automatic logic even_par(input logic [CODE_W-1:0] c);
      return ^c;
   endfunction
endpackage

// File: rtl/evt_hw_capture.sv
module evt_hw_capture #(
   parameter int GROUPS = 4,
   parameter int GSZ    = 16,
   localparam int N     = GROUPS * GSZ,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     trig,
   input  logic [N-1:0]     clr,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   logic [N-1:0] pend;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic [GSZ-1:0] prev;
      logic [GSZ-1:0] rise;
      assign rise = trig[g*GSZ +: GSZ] & ~prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev <= '0;
            pend[g*GSZ +: GSZ] <= '0;
         end else begin
            prev <= trig[g*GSZ +: GSZ];
            pend[g*GSZ +: GSZ] <= (pend[g*GSZ +: GSZ] & ~clr[g*GSZ +: GSZ]) | rise;
         end
      end
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (pend[i]) idx = IDX_W'(i);
   end
   assign any = |pend;
endmodule

// File: rtl/evt_sw_fifo.sv
module evt_sw_fifo #(
   parameter int DEPTH  = 16,
   parameter int W      = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [W-1:0]     din,
   input  logic             rd,
   output logic [W-1:0]     dout,
   output logic             empty,
   output logic             full,
   output logic [CNT_W-1:0] count
);
   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;
   logic             do_wr, do_rd;

   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
   assign do_wr = wr && !full;
   assign do_rd = rd && !empty;
   assign dout  = mem[rp];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_wr) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
         if (do_rd) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
         count <= count + CNT_W'(do_wr) - CNT_W'(do_rd);
      end
   end
endmodule

// File: rtl/evt_frame_ser.sv
module evt_frame_ser
   import evt_link_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              req,
   input  logic [CODE_W-1:0] code,
   output logic              take,
   output logic              line
);
   logic [FRAME_LEN-1:0] shreg;
   logic [CNT_W-1:0]     left;
   logic                 busy;

   assign take = tick && req && (!busy || left == '0);
   assign line = busy && shreg[FRAME_LEN-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         left  <= '0;
         busy  <= 1'b0;
      end else if (take) begin
         shreg <= {1'b1, code, even_par(code), 1'b0};
         left  <= CNT_W'(FRAME_LEN - 1);
         busy  <= 1'b1;
      end else if (tick && busy) begin
         if (left == '0) busy <= 1'b0;
         else begin
            shreg <= shreg << 1;
            left  <= left - 1'b1;
         end
      end
   end
endmodule

// File: rtl/evt_link_tx.sv
module evt_link_tx
   import evt_link_pkg::*;
#(
   parameter int HW_GROUPS = 4,
   parameter int SW_DEPTH  = 16,
   parameter int WIN_W     = 16,
   localparam int HW_N     = HW_GROUPS * GROUP_SZ,
   localparam int HIDX_W   = (HW_N > 1) ? $clog2(HW_N) : 1,
   localparam int FCNT_W   = $clog2(SW_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic [HW_N-1:0]   hw_trig,
   input  logic              sw_wr,
   input  logic [CODE_W-1:0] sw_code,
   input  logic              cycle_start,
   input  logic [WIN_W-1:0]  win_len,
   output logic              link_out,
   output logic              sw_err,
   output logic              sw_full
);
   if (HW_GROUPS < 1 || HW_N > HW_LIMIT) begin : g_bad_groups
      $error("evt_link_tx: hardware codes must fit below the software range");
   end
   if (SW_DEPTH < 2) begin : g_bad_depth
      $error("evt_link_tx: software queue depth must be at least 2");
   end

   logic              hw_any, take, sw_empty, sw_ok, win_on;
   logic [HIDX_W-1:0] hw_idx;
   logic [HW_N-1:0]   hw_clr;
   logic [CODE_W-1:0] sw_head, tx_code;
   logic [FCNT_W-1:0] fifo_cnt;
   logic [WIN_W-1:0]  win_cnt;
   logic              sw_legal;

   assign sw_legal = (sw_code >= CODE_W'(HW_LIMIT));
   assign win_on   = (win_cnt != '0);
   assign sw_ok    = !sw_empty && !win_on;
   assign tx_code  = hw_any ? CODE_W'(hw_idx) : sw_head;
   assign hw_clr   = (take && hw_any) ? (HW_N'(1) << hw_idx) : '0;

   evt_hw_capture #(.GROUPS(HW_GROUPS), .GSZ(GROUP_SZ)) hw_i (
      .clk(clk), .rst_n(rst_n), .trig(hw_trig), .clr(hw_clr),
      .any(hw_any), .idx(hw_idx)
   );

   evt_sw_fifo #(.DEPTH(SW_DEPTH), .W(CODE_W)) fifo_i (
      .clk(clk), .rst_n(rst_n), .wr(sw_wr && sw_legal), .din(sw_code),
      .rd(take && !hw_any), .dout(sw_head), .empty(sw_empty),
      .full(sw_full), .count(fifo_cnt)
   );

   evt_frame_ser ser_i (
      .clk(clk), .rst_n(rst_n), .tick(bit_tick), .req(hw_any || sw_ok),
      .code(tx_code), .take(take), .line(link_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
         sw_err  <= 1'b0;
      end else begin
         if (cycle_start)            win_cnt <= win_len;
         else if (bit_tick && win_on) win_cnt <= win_cnt - 1'b1;
         if (sw_wr && !sw_legal)     sw_err  <= 1'b1;
      end
   end
endmodule

// File: rtl/evt_link_tx_chk.sv
module evt_link_tx_chk
   import evt_link_pkg::*;
#(
   parameter int SW_DEPTH = 16,
   parameter int FCNT_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_tick,
   input logic              sw_wr,
   input logic [CODE_W-1:0] sw_code,
   input logic              link_out,
   input logic              sw_err,
   input logic              take,
   input logic [CODE_W-1:0] tx_code,
   input logic              win_on,
   input logic              hw_any,
   input logic [FCNT_W-1:0] fifo_cnt
);
   // R2
   link_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(link_out));
   // R6
   sw_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr && sw_code < CODE_W'(HW_LIMIT)) |=> sw_err);
   // R6
   sw_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_err |=> sw_err);
   // R7
   window_hw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && win_on) |-> (tx_code < CODE_W'(HW_LIMIT)));
   // R4
   hw_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && hw_any) |-> (tx_code < CODE_W'(HW_LIMIT)));
   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= FCNT_W'(SW_DEPTH));
endmodule

bind evt_link_tx evt_link_tx_chk #(.SW_DEPTH(SW_DEPTH), .FCNT_W(FCNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sw_wr(sw_wr),
   .sw_code(sw_code), .link_out(link_out), .sw_err(sw_err), .take(take),
   .tx_code(tx_code), .win_on(win_on), .hw_any(hw_any), .fifo_cnt(fifo_cnt)
);

// File: tb/evt_link_tx_tb_top.sv
module evt_link_tx_tb_top;
   localparam int HW_N = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bit_tick = 1'b0;
   logic [HW_N-1:0] hw_trig = '0;
   logic            sw_wr = 1'b0;
   logic [7:0]      sw_code = '0;
   logic            cycle_start = 1'b0;
   logic [15:0]     win_len = '0;
   logic            link_out, sw_err, sw_full;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [1:0] tdiv = '0;

   always #2 clk = ~clk;

   always @(posedge clk) begin
      cyc  <= cyc + 1;
      tdiv <= tdiv + 1'b1;
      bit_tick <= (tdiv == 2'd2);
   end

   evt_link_tx dut_i (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .hw_trig(hw_trig),
      .sw_wr(sw_wr), .sw_code(sw_code), .cycle_start(cycle_start),
      .win_len(win_len), .link_out(link_out), .sw_err(sw_err), .sw_full(sw_full)
   );

   // {is_sw, stimulus code, expected code}
   localparam logic [16:0] VEC [8] = '{
      {1'b0, 8'd0,   8'd0},   {1'b0, 8'd63,  8'd63},
      {1'b0, 8'd17,  8'd17},  {1'b1, 8'd64,  8'd64},
      {1'b1, 8'd255, 8'd255}, {1'b1, 8'd170, 8'd170},
      {1'b0, 8'd42,  8'd42},  {1'b1, 8'd129, 8'd129}
   };

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic rx(input int maxcyc, output logic found, output logic [7:0] c,
                     output logic fmt_ok, output int t0);
      logic [10:1] b;
      found = 1'b0; c = '0; fmt_ok = 1'b0; t0 = 0; b = '0;
      for (int n = 0; n < maxcyc && !found; n++) begin
         @(negedge clk);
         if (link_out) begin found = 1'b1; t0 = cyc; end
      end
      if (found) begin
         for (int k = 1; k <= 10; k++) begin
            repeat (4) @(negedge clk);
            b[k] = link_out;
         end
         c = b[8:1] == b[8:1] ? {b[1], b[2], b[3], b[4], b[5], b[6], b[7], b[8]} : '0;
         fmt_ok = ((^c) == b[9]) && (b[10] == 1'b0);
      end
   endtask

   task automatic hw_pulse(input int i);
      @(negedge clk); hw_trig[i] = 1'b1;
      @(negedge clk); hw_trig[i] = 1'b0;
   endtask

   task automatic sw_put(input logic [7:0] c);
      @(negedge clk); sw_wr = 1'b1; sw_code = c;
      @(negedge clk); sw_wr = 1'b0;
   endtask

   task automatic expect_frame(input string req, input int exp, input int maxcyc);
      logic f, ok; logic [7:0] c; int t0;
      rx(maxcyc, f, c, ok, t0);
      chk(f, req, int'(f), 1);
      chk(c == 8'(exp), req, int'(c), exp);
      chk(ok, "R2", int'(ok), 1);
   endtask

   task automatic expect_quiet(input string req, input int ncyc);
      logic f, ok; logic [7:0] c; int t0;
      rx(ncyc, f, c, ok, t0);
      chk(!f, req, int'(c), -1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic f, ok; logic [7:0] c; int t0, ts;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(link_out == 1'b0, "R1", int'(link_out), 0);
      chk(sw_err == 1'b0, "R1", int'(sw_err), 0);
      chk(sw_full == 1'b0, "R1", int'(sw_full), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2 R3 R5: single events from the vector table
      for (int v = 0; v < 8; v++) begin
         if (VEC[v][16]) sw_put(VEC[v][15:8]);
         else            hw_pulse(int'(VEC[v][15:8]));
         expect_frame(VEC[v][16] ? "R5" : "R3", int'(VEC[v][7:0]), 200);
      end

      // R4 priority: events gathered while a frame is on the line
      sw_put(8'd100);
      fork
         begin
            rx(200, f, c, ok, t0);
            chk(c == 8'd100, "R4", int'(c), 100);
         end
         begin
            repeat (12) @(negedge clk);
            sw_wr = 1'b1; sw_code = 8'd150; hw_trig[9] = 1'b1; hw_trig[2] = 1'b1;
            @(negedge clk);
            sw_wr = 1'b0; hw_trig[9] = 1'b0; hw_trig[2] = 1'b0;
         end
      join
      expect_frame("R4", 2, 100);
      expect_frame("R4", 9, 100);
      expect_frame("R4", 150, 100);

      // R3 a held trigger gives one event
      @(negedge clk); hw_trig[33] = 1'b1;
      expect_frame("R3", 33, 100);
      expect_quiet("R3", 120);
      hw_trig[33] = 1'b0;

      // R7 window holds software, lets hardware through
      @(negedge clk);
      win_len = 16'd40; cycle_start = 1'b1; sw_wr = 1'b1; sw_code = 8'd77;
      ts = cyc;
      @(negedge clk);
      cycle_start = 1'b0; sw_wr = 1'b0; hw_trig[20] = 1'b1;
      @(negedge clk); hw_trig[20] = 1'b0;
      expect_frame("R7", 20, 100);
      rx(400, f, c, ok, t0);
      chk(f && c == 8'd77, "R7", int'(c), 77);
      chk(t0 - ts >= 156, "R7", t0 - ts, 156);

      // R8 zero-length window
      @(negedge clk);
      win_len = 16'd0; cycle_start = 1'b1; sw_wr = 1'b1; sw_code = 8'd90;
      @(negedge clk);
      cycle_start = 1'b0; sw_wr = 1'b0;
      expect_frame("R8", 90, 20);

      // R5 fill the queue behind a long window
      @(negedge clk);
      win_len = 16'd300; cycle_start = 1'b1;
      @(negedge clk); cycle_start = 1'b0;
      for (int i = 0; i < 16; i++) begin
         sw_wr = 1'b1; sw_code = 8'(64 + i);
         @(negedge clk);
      end
      sw_wr = 1'b0;
      chk(sw_full == 1'b1, "R5", int'(sw_full), 1);
      sw_put(8'd80);
      chk(sw_err == 1'b0, "R5", int'(sw_err), 0);
      for (int i = 0; i < 16; i++)
         expect_frame("R5", 64 + i, (i == 0) ? 1400 : 100);
      chk(sw_full == 1'b0, "R5", int'(sw_full), 0);
      expect_quiet("R5", 120);

      // R6 low code rejected and sticky
      sw_put(8'd10);
      chk(sw_err == 1'b1, "R6", int'(sw_err), 1);
      expect_quiet("R6", 120);
      sw_put(8'd200);
      expect_frame("R6", 200, 100);
      chk(sw_err == 1'b1, "R6", int'(sw_err), 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule